// File: doc/BRIEF.md
# Delta Modulation Codec

This block encodes a stream of signed fixed-point samples as one bit per sample and decodes such a bit stream back into a signed word. The encoding side keeps a running estimate of the input. For each accepted sample it sends a single bit that tells whether the sample lies at or above that estimate. It then moves the estimate one step in the direction that bit gives. The decoding side is a copy of the same estimate tracker, driven only by the received bits. Its output therefore reproduces the encoder's estimate exactly, one cycle after each received bit.

The step can be fixed or adaptive. With a fixed step, the programmed minimum step is used. With adaptation, a run of equal bits shows that the input is outrunning the estimate (slope overload), and the step grows. A change of bit shows that the estimate is hunting around the input, and the step shrinks. Both estimates saturate at the signed full-scale limits and never wrap. In normal use the code output is looped, over any serial link, into the code input of a matching decoder.

Top module: `delta_codec`

## Requirements
- R1: A synchronous reset clears both estimates to zero, deasserts `code_valid`, and loads the step with `step_min`, so that encoder and decoder start aligned.
- R2: For a sample accepted while `in_valid` is high, `code_bit` is 1 when the sample is greater than or equal to the encoder estimate, including the case of equality, and 0 otherwise. The bit is presented with `code_valid` high on the following cycle.
- R3: When `adapt_en` is low, each accepted bit moves the estimate by exactly `step_min`: up for a 1 and down for a 0.
- R4: An estimate that would pass the signed limits of `W` bits is clamped to the largest or smallest value instead of wrapping.
- R5: When `adapt_en` is high, an accepted bit that completes a run of three or more equal bits doubles the step for the next sample. The doubled step is capped at `step_max`.
- R6: When `adapt_en` is high, an accepted bit that differs from the previous bit halves the step for the next sample. The halved step is floored at `step_min`.
- R7: On the cycle after `rx_valid`, `recon` equals the estimate that the encoder formed from the same bit sequence under the same settings.
- R8: Cycles without `in_valid` produce no code (`code_valid` low). Cycles without `rx_valid` leave `recon` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adapt_en | input | 1 | 1 selects the adaptive step, 0 selects a fixed step of `step_min` |
| step_min | input | W-1 | Fixed step, and the lower bound of the adaptive step |
| step_max | input | W-1 | Upper bound of the adaptive step |
| in_valid | input | 1 | The sample on `in_sample` is accepted this cycle |
| in_sample | input | W | Signed input sample |
| code_bit | output | 1 | Encoded bit: 1 means the estimate steps up |
| code_valid | output | 1 | `code_bit` holds a new code this cycle |
| rx_bit | input | 1 | Received code bit |
| rx_valid | input | 1 | `rx_bit` is accepted this cycle |
| recon | output | W | Signed reconstructed estimate |

## Verification
A sample accepted at a clock edge has its code bit due on the output at the next edge. When that bit is looped into the decoder, the reconstructed word is due one edge later, two edges after the sample. The bench drives inputs on the falling edge. On every falling edge it checks the code expected from the sample one cycle back, and the `recon` value expected from the sample two cycles back. In cycles with no pending sample, it checks that `recon` has held its last value and that no code was produced. Settings change only while the pipeline is idle, so the bench model and both stages see the same configuration.

// File: rtl/delta_codec.sv
module delta_codec #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adapt_en,
  input  logic [W-2:0]        step_min,
  input  logic [W-2:0]        step_max,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_sample,
  output logic                code_bit,
  output logic                code_valid,
  input  logic                rx_bit,
  input  logic                rx_valid,
  output logic signed [W-1:0] recon
);
  localparam int SW = W - 1;
  localparam logic signed [W:0] HI = (W+1)'(2**(W-1) - 1);
  localparam logic signed [W:0] LO = -(W+1)'(2**(W-1));

  for (genvar g = 0; g < 2; g++) begin : lane
    logic signed [W-1:0] acc;
    logic [SW-1:0]       stp;
    logic [1:0]          run;
    logic                prv;

    wire fire = (g == 0) ? in_valid : rx_valid;
    wire b    = (g == 0) ? (in_sample >= acc) : rx_bit;

    wire [SW-1:0]        use_stp = adapt_en ? stp : step_min;
    wire signed [W:0]    ext     = $signed({2'b00, use_stp});
    wire signed [W:0]    sum     = $signed({acc[W-1], acc}) + (b ? ext : -ext);
    wire signed [W-1:0]  acc_n   = (sum > HI) ? HI[W-1:0] :
                                   (sum < LO) ? LO[W-1:0] : sum[W-1:0];

    wire [SW:0]          dbl  = {stp, 1'b0};
    wire [SW-1:0]        up   = (dbl > {1'b0, step_max}) ? step_max : dbl[SW-1:0];
    wire [SW-1:0]        half = stp >> 1;
    wire [SW-1:0]        dn   = (half < step_min) ? step_min : half;
    wire                 flip = (run != 2'd0) && (b != prv);
    wire [1:0]           run_n = flip ? 2'd1 : (run == 2'd3) ? 2'd3 : run + 2'd1;
    wire [SW-1:0]        stp_n = !adapt_en ? step_min :
                                 flip ? dn : (run_n == 2'd3) ? up : stp;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc <= '0;
        stp <= step_min;
        run <= '0;
        prv <= 1'b0;
      end else if (fire) begin
        acc <= acc_n;
        stp <= stp_n;
        run <= run_n;
        prv <= b;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_valid <= 1'b0;
      code_bit   <= 1'b0;
    end else begin
      code_valid <= in_valid;
      if (in_valid) code_bit <= lane[0].b;
    end
  end

  assign recon = lane[1].acc;
endmodule

module delta_codec_chk #(
  parameter int W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                code_valid,
  input logic                rx_bit,
  input logic                rx_valid,
  input logic signed [W-1:0] recon
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (recon == '0 && !code_valid));
  // R2
  code_timing_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> code_valid);
  // R8
  no_code_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !code_valid);
  // R8
  recon_hold_chk: assert property (@(posedge clk) disable iff (rst) !rx_valid |=> $stable(recon));
  // R3
  step_up_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_bit) |=> (recon >= $past(recon)));
  // R3
  step_dn_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_bit) |=> (recon <= $past(recon)));
endmodule

bind delta_codec delta_codec_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .code_valid(code_valid),
  .rx_bit(rx_bit), .rx_valid(rx_valid), .recon(recon)
);

// File: tb/delta_codec_tb.sv
module delta_codec_tb;
  localparam int W  = 12;
  localparam int SW = W - 1;
  localparam int HI = 2**(W-1) - 1;
  localparam int LO = -(2**(W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adapt_en = 1'b0;
  logic [SW-1:0] step_min = 11'd4;
  logic [SW-1:0] step_max = 11'd64;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic code_bit, code_valid;
  logic signed [W-1:0] recon;

  always #5 clk = ~clk;

  delta_codec #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .adapt_en(adapt_en), .step_min(step_min), .step_max(step_max),
    .in_valid(in_valid), .in_sample(in_sample), .code_bit(code_bit), .code_valid(code_valid),
    .rx_bit(code_bit), .rx_valid(code_valid), .recon(recon)
  );

  int n_chk = 0, n_bad = 0;

  // bench model state
  int m_q, m_step, m_run, m_prev;
  // pipeline of expectations
  bit p1_v, p1_bit; int p1_q;
  bit p2_v; int p2_q;
  int exp_recon;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_q = 0; m_step = step_min; m_run = 0; m_prev = 0;
    p1_v = 0; p1_bit = 0; p1_q = 0; p2_v = 0; p2_q = 0; exp_recon = 0;
  endtask

  // returns code bit; updates model estimate and step
  task automatic model_step(input int x, output bit b);
    int used, nq;
    bit changed;
    b = (x >= m_q);
    used = adapt_en ? m_step : int'(step_min);
    nq = b ? m_q + used : m_q - used;
    if (nq > HI) nq = HI;
    if (nq < LO) nq = LO;
    m_q = nq;
    changed = (m_run > 0) && (b != m_prev);
    if (changed) m_run = 1;
    else if (m_run < 3) m_run = m_run + 1;
    if (!adapt_en) m_step = step_min;
    else if (changed) m_step = (m_step / 2 < step_min) ? int'(step_min) : m_step / 2;
    else if (m_run == 3) m_step = (m_step * 2 > step_max) ? int'(step_max) : m_step * 2;
    m_prev = b;
  endtask

  // one cycle: check pending results, then drive new stimulus
  task automatic tick(input bit v, input int x, input string req);
    bit b;
    @(negedge clk);
    if (p1_v) begin
      check(code_valid === 1'b1, {req, " R2 valid"}, code_valid, 1);
      check(code_bit === p1_bit, {req, " R2 bit"}, code_bit, p1_bit);
    end else
      check(code_valid === 1'b0, {req, " R8 idle code"}, code_valid, 0);
    if (p2_v) exp_recon = p2_q;
    check(recon == exp_recon, {req, " R7 recon"}, recon, exp_recon);
    p2_v = p1_v; p2_q = p1_q;
    in_valid  = v;
    in_sample = x[W-1:0];
    if (v) begin
      model_step(x, b);
      p1_v = 1; p1_bit = b; p1_q = m_q;
    end else p1_v = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    // R1: estimates and code cleared
    check(recon == 0, "R1 recon", recon, 0);
    check(code_valid === 1'b0, "R1 code_valid", code_valid, 0);
    model_reset();
  endtask

  task automatic drain();
    tick(0, 0, "drain"); tick(0, 0, "drain"); tick(0, 0, "drain");
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    repeat (2) @(negedge clk);
    do_reset();

    // R2: equal to estimate (0 vs 0) gives a 1
    tick(1, 0, "R2 equal");
    tick(1, -1, "R2 below");
    drain();

    // R3: fixed step ramp up and down
    for (int i = 0; i < 8; i++) tick(1, 1000, "R3 up");
    for (int i = 0; i < 8; i++) tick(1, -1000, "R3 down");
    drain();

    // R4: saturation at both limits
    step_min = 11'd1500; do_reset();
    for (int i = 0; i < 5; i++) tick(1, HI, "R4 high");
    for (int i = 0; i < 6; i++) tick(1, LO, "R4 low");
    drain();

    // R5: adaptive growth under slope overload, capped at step_max
    step_min = 11'd2; step_max = 11'd32; adapt_en = 1; do_reset();
    for (int i = 0; i < 12; i++) tick(1, 1500, "R5 grow");
    // R6: alternation halves toward step_min
    for (int i = 0; i < 10; i++) tick(1, (i % 2) ? -2000 : 2000, "R6 shrink");
    for (int i = 0; i < 10; i++) tick(1, 100, "R6 hunt");
    drain();

    // R8: long idle gap keeps recon
    for (int i = 0; i < 5; i++) tick(0, 777, "R8 gap");

    // random stimulus, several configurations, R7 tracking
    for (int c = 0; c < 4; c++) begin
      adapt_en = c[0];
      step_min = SW'(1 + $urandom_range(0, 15));
      step_max = SW'(int'(step_min) + $urandom_range(0, 400));
      do_reset();
      for (int i = 0; i < 300; i++) begin
        int x;
        x = $urandom_range(0, 4095) - 2048;
        tick(($urandom_range(0, 3) != 0), x, "R7 random");
      end
      drain();
    end

    // mid-run reset restarts aligned
    adapt_en = 1; step_min = 11'd3; step_max = 11'd200;
    for (int i = 0; i < 6; i++) tick(1, 1800, "R1 pre");
    do_reset();
    for (int i = 0; i < 6; i++) tick(1, -300, "R1 post");
    drain();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule